// File: doc/BRIEF.md
# UART Parity Generator and Checker

This block sits beside a UART serializer and deserializer and deals only with the parity bit of a character. A set of control inputs picks one of four parity modes: disabled, odd, even, or stick (a fixed bit). On the transmit side it reads a data byte and a character length of 5 to 8 bits. From these it forms the parity bit and a flag that says whether a parity bit goes on the line.

On the receive side it takes the assembled data bits and the sampled parity bit, marked by a valid strobe. One cycle later it raises a registered error pulse when the sampled bit disagrees with the expected bit. Start and stop bits, bit timing, shifting and buffering are handled elsewhere.

Top module: `uart_parity_unit`

## Requirements
- R1: With `par_en`=1, `stick_sel`=0 and `even_sel`=1 (even mode), `tx_par_bit` makes the count of ones over the active data bits plus the parity bit even.
- R2: With `par_en`=1, `stick_sel`=0 and `even_sel`=0 (odd mode), `tx_par_bit` makes that same count odd.
- R3: With `par_en`=0, the other two control bits are ignored. `tx_par_send` and `tx_par_bit` are both 0, and `par_err` never rises.
- R4: With `par_en`=1 and `stick_sel`=1, `tx_par_bit` equals the inverse of `even_sel` for every data value.
- R5: `char_len` picks the active low data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the active length have no effect on either the parity bit or the error check.
- R6: `tx_par_bit` and `tx_par_send` are combinational and settle in the same cycle as the inputs. `tx_par_send` is 1 whenever `par_en`=1.
- R7: In the cycle after `rx_valid`=1, `par_err` is high exactly when `rx_par_bit` differs from the bit that the current mode and length expect for `rx_data`. `par_err` is low in any cycle that does not follow `rx_valid`.
- R8: A synchronous active-high `rst` forces `par_err` to 0 at the next clock edge, even if `rx_valid` and a mismatch are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| par_en | input | 1 | Parity enable; 0 selects no parity |
| even_sel | input | 1 | 1 selects even parity; in stick mode the parity bit is its inverse |
| stick_sel | input | 1 | 1 selects a fixed parity bit |
| char_len | input | 2 | Character length code, 5 to 8 bits |
| tx_data | input | 8 | Outgoing character, LSB-aligned |
| tx_par_bit | output | 1 | Parity bit for the outgoing character |
| tx_par_send | output | 1 | High when a parity bit is to be sent |
| rx_data | input | 8 | Received character, LSB-aligned |
| rx_par_bit | input | 1 | Sampled parity bit |
| rx_valid | input | 1 | Received character and parity bit are valid |
| par_err | output | 1 | One-cycle parity error pulse |

## Verification
The transmit parity path and the receive check share the mode and length inputs. Both can therefore be active in the same cycle, each working on its own byte. The bench provokes this by driving `tx_data` with the complement of `rx_data` while `rx_valid` is high. It then judges the combinational transmit bit in that cycle and the error pulse in the next, each against a population count the bench computes itself. The sweep covers every mode, every length and every byte, and it offers both values of the received parity bit.

// File: rtl/uart_parity_unit.sv
module uart_parity_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       par_en,
  input  logic       even_sel,
  input  logic       stick_sel,
  input  logic [1:0] char_len,
  input  logic [7:0] tx_data,
  output logic       tx_par_bit,
  output logic       tx_par_send,
  input  logic [7:0] rx_data,
  input  logic       rx_par_bit,
  input  logic       rx_valid,
  output logic       par_err
);
  localparam int DATA_W = 8;

  logic [DATA_W-1:0] len_mask;
  logic              tx_xor, rx_xor;
  logic              tx_expect, rx_expect;

  assign len_mask = {DATA_W{1'b1}} >> (2'd3 - char_len);

  assign tx_xor = ^(tx_data & len_mask);
  assign rx_xor = ^(rx_data & len_mask);

  assign tx_expect = stick_sel ? ~even_sel : (even_sel ? tx_xor : ~tx_xor);
  assign rx_expect = stick_sel ? ~even_sel : (even_sel ? rx_xor : ~rx_xor);

  assign tx_par_send = par_en;
  assign tx_par_bit  = par_en & tx_expect;

  always_ff @(posedge clk) begin
    if (rst) par_err <= 1'b0;
    else     par_err <= rx_valid & par_en & (rx_par_bit ^ rx_expect);
  end
endmodule

module uart_parity_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       par_en,
  input logic       even_sel,
  input logic       stick_sel,
  input logic [1:0] char_len,
  input logic [7:0] tx_data,
  input logic       tx_par_bit,
  input logic       tx_par_send,
  input logic       rx_valid,
  input logic       par_err
);
  logic [7:0] act;
  int         ones;
  always_comb begin
    act = 8'h00;
    for (int i = 0; i < 8; i++)
      if (i < 5 + int'(char_len)) act[i] = tx_data[i];
    ones = $countones(act) + int'(tx_par_bit);
  end

  assert_even_total_R1: assert property (@(posedge clk) disable iff (rst)
    (par_en && !stick_sel && even_sel) |-> (ones % 2 == 0));

  assert_odd_total_R2: assert property (@(posedge clk) disable iff (rst)
    (par_en && !stick_sel && !even_sel) |-> (ones % 2 == 1));

  assert_none_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !par_en |-> (!tx_par_send && !tx_par_bit));

  assert_none_no_err_R3: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !par_en) |=> !par_err);

  assert_stick_fixed_R4: assert property (@(posedge clk) disable iff (rst)
    (par_en && stick_sel) |-> (tx_par_bit == !even_sel));

  assert_send_flag_R6: assert property (@(posedge clk) disable iff (rst)
    par_en |-> tx_par_send);

  assert_err_after_valid_R7: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> !par_err);

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !par_err);
endmodule

bind uart_parity_unit uart_parity_unit_chk u_chk (
  .clk(clk), .rst(rst), .par_en(par_en), .even_sel(even_sel),
  .stick_sel(stick_sel), .char_len(char_len), .tx_data(tx_data),
  .tx_par_bit(tx_par_bit), .tx_par_send(tx_par_send),
  .rx_valid(rx_valid), .par_err(par_err)
);

// File: tb/test_uart_parity_unit.sv
module test_uart_parity_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       par_en, even_sel, stick_sel;
  logic [1:0] char_len;
  logic [7:0] tx_data, rx_data;
  logic       rx_par_bit, rx_valid;
  logic       tx_par_bit, tx_par_send, par_err;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  uart_parity_unit i_uart_parity_unit (
    .clk(clk), .rst(rst), .par_en(par_en), .even_sel(even_sel),
    .stick_sel(stick_sel), .char_len(char_len), .tx_data(tx_data),
    .tx_par_bit(tx_par_bit), .tx_par_send(tx_par_send),
    .rx_data(rx_data), .rx_par_bit(rx_par_bit), .rx_valid(rx_valid),
    .par_err(par_err)
  );

  function automatic logic ref_bit(input logic [7:0] d, input logic [1:0] len,
                                   input logic en, input logic ev, input logic st);
    int pop = 0;
    for (int i = 0; i < 5 + int'(len); i++) pop += int'(d[i]);
    if (!en) return 1'b0;
    if (st)  return !ev;
    return ev ? logic'(pop % 2) : logic'(1 - pop % 2);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (en=%b ev=%b st=%b len=%0d tx=%h rx=%h)",
               req, act, exp, par_en, even_sel, stick_sel, char_len, tx_data, rx_data);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; par_en = 1'b1; even_sel = 1'b0; stick_sel = 1'b0;
    char_len = 2'd3; tx_data = 8'h00; rx_data = 8'h00;
    rx_par_bit = 1'b0; rx_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset state", par_err, 1'b0);

    // R8: reset wins over a mismatch presented with rx_valid
    rx_data = 8'h01; rx_par_bit = 1'b1; rx_valid = 1'b1;
    @(negedge clk);
    check("R8 reset over mismatch", par_err, 1'b0);
    rx_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    for (int m = 0; m < 8; m++) begin
      for (int l = 0; l < 4; l++) begin
        for (int d = 0; d < 256; d++) begin
          for (int pb = 0; pb < 2; pb++) begin
            logic ex_rx, ex_tx;
            par_en = m[2]; even_sel = m[1]; stick_sel = m[0];
            char_len = 2'(l);
            rx_data = 8'(d); tx_data = ~8'(d);
            rx_par_bit = pb[0]; rx_valid = 1'b1;
            ex_rx = ref_bit(rx_data, char_len, par_en, even_sel, stick_sel);
            ex_tx = ref_bit(tx_data, char_len, par_en, even_sel, stick_sel);
            #1;
            // same-cycle tx result while rx check is in flight (R1 R2 R4 R5 R6, R3 when disabled)
            check(par_en ? (stick_sel ? "R4 stick tx" : (even_sel ? "R1 even tx" : "R2 odd tx"))
                         : "R3 none tx", tx_par_bit, ex_tx);
            check(par_en ? "R6 send flag" : "R3 send flag", tx_par_send, par_en);
            @(negedge clk);
            rx_valid = 1'b0;
            #1;
            check(par_en ? "R7 R5 rx error" : "R3 none rx", par_err,
                  par_en & (rx_par_bit ^ ex_rx));
            @(negedge clk);
            check("R7 one-cycle pulse", par_err, 1'b0);
          end
        end
      end
    end

    // R5: bits above length ignored, 5-bit length, upper bits flipped
    par_en = 1'b1; even_sel = 1'b1; stick_sel = 1'b0; char_len = 2'd0;
    tx_data = 8'b0000_0011; #1;
    check("R5 upper ignored a", tx_par_bit, 1'b0);
    tx_data = 8'b1110_0011; #1;
    check("R5 upper ignored b", tx_par_bit, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule